// File: doc/BRIEF.md
# Multi-Stream Stride Data Prefetcher

This block watches the stream of block addresses that a data cache looks up and produces prefetch requests for blocks it expects to be needed soon. A 2-bit mode input selects one of four policies. In the miss-driven policy, a miss produces a request for the next block. In the every-access policy, every lookup produces a request for the next block. In the stride policy, a table of independent streams learns constant strides and runs ahead along each confirmed one. The fourth setting turns prefetching off.

In stride mode, every access is matched against the tracked streams by address proximity. A stream is confirmed once it has seen three accesses spaced by the same non-zero stride. After that, the unit issues requests further along the stride, one per idle cycle, up to a fixed number of lines ahead of the latest access. Requests wait in a small FIFO in front of a valid/ready request port. Fill logic and filtering against cache contents live elsewhere.

Top module: `pf_stride_prefetcher`

## Requirements
- R1: After reset, and after a reset applied while requests are queued, `pf_valid_o` is low and no queued request is delivered afterwards.
- R2: With `mode_i` = 2'b00, an access with `acc_miss_i` = 1 to block b produces exactly one request for b+1 (modulo 2^ADDR_W). An access with `acc_miss_i` = 0 produces none.
- R3: With `mode_i` = 2'b01, every access to block b produces exactly one request for b+1, whatever the value of `acc_miss_i`.
- R4: With `mode_i` = 2'b10, accesses to b, b+N and b+2N with N non-zero and |N| ≤ SPAN confirm a stream. In the idle cycles that follow, requests for b+3N, b+4N and so on are delivered in that order. Negative N is supported.
- R5: A confirmed stream stays at most MAX_AHEAD (12) lines ahead. With no further accesses it stops after b+(2+MAX_AHEAD)N. Each later access that continues the stride allows exactly one more request, for the latest access plus MAX_AHEAD·N.
- R6: An access that falls within a stream's span but breaks its stride clears that stream's confirmation and stops its requests. Two further equal steps are needed before requests resume, and they resume from the new stride.
- R7: A stride of zero never confirms. Repeated accesses to the same block produce no requests in stride mode.
- R8: Up to STREAMS (8) streams are tracked and served independently. Pending run-ahead work is served lowest table slot first. An access near no tracked stream takes the least recently allocated slot.
- R9: While `pf_ready_i` is low, `pf_valid_o` stays high and `pf_blk_o` stays stable. Up to Q_DEPTH (4) requests are held and later delivered in order. Next-line requests arriving while the queue is full are dropped. Stride run-ahead waits for queue space.
- R10: With `mode_i` = 2'b11, no request is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | 00 miss-next, 01 every-access-next, 10 stride, 11 off |
| acc_valid_i | input | 1 | A cache lookup is presented this cycle |
| acc_blk_i | input | ADDR_W | Block address of the lookup |
| acc_miss_i | input | 1 | The lookup missed |
| pf_valid_o | output | 1 | A prefetch request is offered |
| pf_blk_o | output | ADDR_W | Block address to prefetch |
| pf_ready_i | input | 1 | The consumer accepts the offered request |

## Verification
The bench targets several corner cases and the failure each one exposes. The run-ahead cap is checked by counting requests after confirmation: an off-by-one would show one line too many or too few. The stride break is checked by looking for silence after a stride change: a design that only re-trained the stride would keep prefetching. Zero stride, the address wrap at all-ones, and negative strides are each driven directly. Eight interleaved streams are followed by a ninth allocation, which shows whether the oldest slot was evicted or a younger one was. A full queue under backpressure shows whether requests are lost or reordered, and whether the offered address shifts while it is stalled.

// File: rtl/pf_pkg.sv
package pf_pkg;

  typedef enum logic [1:0] {
    PF_ON_MISS   = 2'b00,
    PF_LOOKAHEAD = 2'b01,
    PF_STRIDE    = 2'b10,
    PF_OFF       = 2'b11
  } pf_mode_e;

  typedef enum logic [1:0] {
    TRK_EMPTY = 2'd0,
    TRK_ONE   = 2'd1,
    TRK_TRAIN = 2'd2,
    TRK_CONF  = 2'd3
  } trk_state_e;

endpackage

// File: rtl/pf_next_line.sv
module pf_next_line
  import pf_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  pf_mode_e          mode,
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_blk,
  input  logic              acc_miss,
  output logic              nl_valid,
  output logic [ADDR_W-1:0] nl_blk
);

  function automatic logic [ADDR_W-1:0] succ_blk(input logic [ADDR_W-1:0] b);
    return b + ADDR_W'(1);
  endfunction

  always_comb begin
    nl_valid = 1'b0;
    if (acc_valid) begin
      unique case (mode)
        PF_ON_MISS:   nl_valid = acc_miss;
        PF_LOOKAHEAD: nl_valid = 1'b1;
        default:      nl_valid = 1'b0;
      endcase
    end
    nl_blk = succ_blk(acc_blk);
  end

endmodule

// File: rtl/pf_stream_table.sv
module pf_stream_table
  import pf_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int STREAMS   = 8,
  parameter int SPAN      = 64,
  parameter int MAX_AHEAD = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_blk,
  input  logic              space_ok,
  output logic              req_valid,
  output logic [ADDR_W-1:0] req_blk,
  output logic              conf_evt,
  output logic              bg_fire
);

  localparam int IDX_W = (STREAMS > 1) ? $clog2(STREAMS) : 1;
  localparam int AH_W  = $clog2(MAX_AHEAD + 1);

  trk_state_e        st_q     [STREAMS];
  logic [ADDR_W-1:0] last_q   [STREAMS];
  logic [ADDR_W-1:0] stride_q [STREAMS];
  logic [AH_W-1:0]   ahead_q  [STREAMS];
  logic [IDX_W-1:0]  alloc_q;

  logic [ADDR_W-1:0] delta [STREAMS];
  logic [STREAMS-1:0] near;
  logic [STREAMS-1:0] cand;

  // signed distance test against the tracking window
  function automatic logic within_span(input logic [ADDR_W-1:0] d);
    logic signed [ADDR_W-1:0] sd;
    logic signed [ADDR_W-1:0] lim;
    sd  = $signed(d);
    lim = $signed(ADDR_W'(SPAN));
    return (sd <= lim) && (sd >= -lim);
  endfunction

  // block that lies k strides past the base
  function automatic logic [ADDR_W-1:0] stride_target(
    input logic [ADDR_W-1:0] base,
    input logic [ADDR_W-1:0] step,
    input logic [ADDR_W-1:0] k
  );
    return base + step * k;
  endfunction

  for (genvar e = 0; e < STREAMS; e++) begin : g_slot
    assign delta[e] = acc_blk - last_q[e];
    assign near[e]  = (st_q[e] != TRK_EMPTY) && within_span(delta[e]);
    assign cand[e]  = (st_q[e] == TRK_CONF) && (ahead_q[e] < AH_W'(MAX_AHEAD));
  end

  logic [IDX_W-1:0] hit_idx, bg_idx;
  logic             any_hit, any_cand;

  always_comb begin
    hit_idx  = '0;
    any_hit  = 1'b0;
    bg_idx   = '0;
    any_cand = 1'b0;
    for (int e = STREAMS - 1; e >= 0; e--) begin
      if (near[e]) begin
        hit_idx = IDX_W'(e);
        any_hit = 1'b1;
      end
      if (cand[e]) begin
        bg_idx   = IDX_W'(e);
        any_cand = 1'b1;
      end
    end
  end

  logic              train;
  trk_state_e        nxt_st;
  logic [ADDR_W-1:0] nxt_stride;
  logic [AH_W-1:0]   nxt_ahead;
  logic [ADDR_W-1:0] hd;
  logic [ADDR_W-1:0] hs;
  logic [AH_W-1:0]   ha;

  assign train = en && acc_valid;
  assign hd    = delta[hit_idx];
  assign hs    = stride_q[hit_idx];
  assign ha    = ahead_q[hit_idx];

  always_comb begin
    nxt_stride = hd;
    nxt_ahead  = '0;
    nxt_st     = (hd != '0) ? TRK_TRAIN : TRK_ONE;
    conf_evt   = 1'b0;
    unique case (st_q[hit_idx])
      TRK_TRAIN: begin
        if (hd == hs) begin
          nxt_st   = TRK_CONF;
          conf_evt = train && any_hit;
        end
      end
      TRK_CONF: begin
        if (hd == hs) begin
          nxt_st    = TRK_CONF;
          nxt_ahead = (ha == '0) ? '0 : ha - 1'b1;
        end
      end
      default: ;
    endcase
  end

  assign bg_fire   = en && !acc_valid && any_cand && space_ok;
  assign req_valid = bg_fire;
  assign req_blk   = stride_target(last_q[bg_idx], stride_q[bg_idx],
                                   ADDR_W'(ahead_q[bg_idx]) + ADDR_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int e = 0; e < STREAMS; e++) begin
        st_q[e]     <= TRK_EMPTY;
        last_q[e]   <= '0;
        stride_q[e] <= '0;
        ahead_q[e]  <= '0;
      end
      alloc_q <= '0;
    end else begin
      if (train) begin
        if (any_hit) begin
          st_q[hit_idx]     <= nxt_st;
          last_q[hit_idx]   <= acc_blk;
          stride_q[hit_idx] <= nxt_stride;
          ahead_q[hit_idx]  <= nxt_ahead;
        end else begin
          st_q[alloc_q]     <= TRK_ONE;
          last_q[alloc_q]   <= acc_blk;
          stride_q[alloc_q] <= '0;
          ahead_q[alloc_q]  <= '0;
          alloc_q <= (alloc_q == IDX_W'(STREAMS - 1)) ? '0 : alloc_q + 1'b1;
        end
      end
      if (bg_fire) begin
        ahead_q[bg_idx] <= ahead_q[bg_idx] + 1'b1;
      end
    end
  end

endmodule

// File: rtl/pf_req_queue.sv
module pf_req_queue #(
  parameter int W     = 32,
  parameter int DEPTH = 4,
  localparam int PW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [W-1:0]     push_data,
  input  logic             pop,
  output logic             full,
  output logic             valid,
  output logic [W-1:0]     data,
  output logic [CNT_W-1:0] count
);

  logic [W-1:0]     mem_q [DEPTH];
  logic [PW-1:0]    wr_q, rd_q;
  logic [CNT_W-1:0] cnt_q;
  logic             push_ok, pop_ok;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (cnt_q == CNT_W'(DEPTH));
  assign valid   = (cnt_q != '0);
  assign data    = mem_q[rd_q];
  assign count   = cnt_q;
  assign push_ok = push && !full;
  assign pop_ok  = pop && valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_ok) wr_q <= bump(wr_q);
      if (pop_ok)  rd_q <= bump(rd_q);
      if (push_ok && !pop_ok)      cnt_q <= cnt_q + 1'b1;
      else if (pop_ok && !push_ok) cnt_q <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem_q[wr_q] <= push_data;
  end

endmodule

// File: rtl/pf_stride_prefetcher.sv
module pf_stride_prefetcher
  import pf_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int STREAMS   = 8,
  parameter int SPAN      = 64,
  parameter int MAX_AHEAD = 12,
  parameter int Q_DEPTH   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode_i,
  input  logic              acc_valid_i,
  input  logic [ADDR_W-1:0] acc_blk_i,
  input  logic              acc_miss_i,
  output logic              pf_valid_o,
  output logic [ADDR_W-1:0] pf_blk_o,
  input  logic              pf_ready_i
);

  localparam int CNT_W = $clog2(Q_DEPTH + 1);

  pf_mode_e          mode;
  logic              nl_valid, tb_valid;
  logic [ADDR_W-1:0] nl_blk, tb_blk;
  logic              push_req;
  logic [ADDR_W-1:0] push_blk;
  logic              q_full;
  logic [CNT_W-1:0]  q_count;
  logic              conf_evt, bg_fire;

  assign mode = pf_mode_e'(mode_i);

  pf_next_line #(.ADDR_W(ADDR_W)) u_next (
    .mode      (mode),
    .acc_valid (acc_valid_i),
    .acc_blk   (acc_blk_i),
    .acc_miss  (acc_miss_i),
    .nl_valid  (nl_valid),
    .nl_blk    (nl_blk)
  );

  pf_stream_table #(
    .ADDR_W(ADDR_W), .STREAMS(STREAMS), .SPAN(SPAN), .MAX_AHEAD(MAX_AHEAD)
  ) u_table (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (mode == PF_STRIDE),
    .acc_valid (acc_valid_i),
    .acc_blk   (acc_blk_i),
    .space_ok  (!q_full),
    .req_valid (tb_valid),
    .req_blk   (tb_blk),
    .conf_evt  (conf_evt),
    .bg_fire   (bg_fire)
  );

  assign push_req = (mode == PF_STRIDE) ? tb_valid : nl_valid;
  assign push_blk = (mode == PF_STRIDE) ? tb_blk : nl_blk;

  pf_req_queue #(.W(ADDR_W), .DEPTH(Q_DEPTH)) u_queue (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (push_req),
    .push_data (push_blk),
    .pop       (pf_ready_i),
    .full      (q_full),
    .valid     (pf_valid_o),
    .data      (pf_blk_o),
    .count     (q_count)
  );

endmodule

// File: rtl/pf_stride_prefetcher_chk.sv
module pf_stride_prefetcher_chk #(
  parameter int ADDR_W  = 32,
  parameter int Q_DEPTH = 4,
  parameter int CNT_W   = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        mode_i,
  input logic              acc_valid_i,
  input logic [ADDR_W-1:0] acc_blk_i,
  input logic              acc_miss_i,
  input logic              pf_valid_o,
  input logic [ADDR_W-1:0] pf_blk_o,
  input logic              pf_ready_i,
  input logic              push_req,
  input logic [ADDR_W-1:0] push_blk,
  input logic              q_full,
  input logic [CNT_W-1:0]  q_count,
  input logic              conf_evt,
  input logic              bg_fire
);

  a_r1_idle_after_reset: assert property (@(posedge clk)
    $rose(rst_n) |-> !pf_valid_o);

  a_r2_hit_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid_i && mode_i == 2'b00 && !acc_miss_i) |-> !push_req);

  a_r3_next_line_target: assert property (@(posedge clk) disable iff (!rst_n)
    (push_req && mode_i != 2'b10) |-> (push_blk == acc_blk_i + ADDR_W'(1)));

  a_r4_runahead_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    bg_fire |-> (!acc_valid_i && !q_full && mode_i == 2'b10));

  a_r7_confirm_on_access: assert property (@(posedge clk) disable iff (!rst_n)
    conf_evt |-> (acc_valid_i && mode_i == 2'b10));

  a_r9_hold_while_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (pf_valid_o && !pf_ready_i) |=> (pf_valid_o && $stable(pf_blk_o)));

  a_r9_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    q_count <= CNT_W'(Q_DEPTH));

  a_r10_off_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 2'b11) |-> !push_req);

  logic unused_miss;
  assign unused_miss = acc_miss_i;

endmodule

bind pf_stride_prefetcher pf_stride_prefetcher_chk #(
  .ADDR_W(ADDR_W), .Q_DEPTH(Q_DEPTH), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .acc_valid_i(acc_valid_i),
  .acc_blk_i(acc_blk_i), .acc_miss_i(acc_miss_i), .pf_valid_o(pf_valid_o),
  .pf_blk_o(pf_blk_o), .pf_ready_i(pf_ready_i), .push_req(push_req),
  .push_blk(push_blk), .q_full(q_full), .q_count(q_count),
  .conf_evt(conf_evt), .bg_fire(bg_fire)
);

// File: tb/pf_stride_prefetcher_bench.sv
`timescale 1ns/1ps
module pf_stride_prefetcher_bench;

  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    mode = 2'b00;
  logic          acc_valid = 1'b0;
  logic [AW-1:0] acc_blk = '0;
  logic          acc_miss = 1'b0;
  logic          pf_valid;
  logic [AW-1:0] pf_blk;
  logic          pf_ready = 1'b1;

  int nchk = 0;
  int nfail = 0;
  logic [AW-1:0] cap [0:255];
  int cap_n = 0;

  always #2 clk = ~clk;

  pf_stride_prefetcher u_pf_stride_prefetcher (
    .clk(clk), .rst_n(rst_n), .mode_i(mode), .acc_valid_i(acc_valid),
    .acc_blk_i(acc_blk), .acc_miss_i(acc_miss), .pf_valid_o(pf_valid),
    .pf_blk_o(pf_blk), .pf_ready_i(pf_ready)
  );

  // record every handshake that the coming edge will complete
  always @(negedge clk) begin
    #1;
    if (rst_n && pf_valid && pf_ready) begin
      if (cap_n < 256) cap[cap_n] = pf_blk;
      cap_n = cap_n + 1;
    end
  end

  task automatic chk(input string tag, input logic [AW-1:0] got, input logic [AW-1:0] exp);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic do_acc(input logic [AW-1:0] b, input logic m);
    @(negedge clk);
    acc_valid = 1'b1;
    acc_blk   = b;
    acc_miss  = m;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      acc_valid = 1'b0;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    acc_valid = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // {mode, miss, expect_valid, block, expected block}
  localparam int NV = 9;
  localparam logic [67:0] VEC [0:NV-1] = '{
    {2'b00, 1'b1, 1'b1, 32'd10,         32'd11},
    {2'b00, 1'b0, 1'b0, 32'd20,         32'd0},
    {2'b00, 1'b1, 1'b1, 32'hFFFF_FFFF,  32'd0},
    {2'b01, 1'b0, 1'b1, 32'd30,         32'd31},
    {2'b01, 1'b1, 1'b1, 32'd40,         32'd41},
    {2'b00, 1'b0, 1'b0, 32'd50,         32'd0},
    {2'b11, 1'b1, 1'b0, 32'd60,         32'd0},
    {2'b11, 1'b0, 1'b0, 32'd70,         32'd0},
    {2'b01, 1'b0, 1'b1, 32'd7,          32'd8}
  };

  initial begin
    #400000;
    nfail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    int base;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 valid after reset", AW'(pf_valid), 0);

    // next-line modes and off mode (R2, R3, R10)
    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      mode      = VEC[v][67:66];
      acc_miss  = VEC[v][65];
      acc_blk   = VEC[v][63:32];
      acc_valid = 1'b1;
      @(negedge clk);
      acc_valid = 1'b0;
      #1;
      chk($sformatf("R2/R3/R10 vec %0d valid", v), AW'(pf_valid), AW'(VEC[v][64]));
      if (VEC[v][64]) chk($sformatf("R2/R3 vec %0d block", v), pf_blk, VEC[v][31:0]);
      @(negedge clk);
      #1;
      chk($sformatf("R2/R3/R10 vec %0d drained", v), AW'(pf_valid), 0);
    end

    // R4 and R5: one positive stream, cap of 12
    mode = 2'b10;
    idle(2);
    cap_n = 0;
    do_acc(1000, 1'b0); do_acc(1005, 1'b0); do_acc(1010, 1'b0);
    idle(40);
    chk("R5 run-ahead count", AW'(cap_n), 12);
    for (int k = 0; k < 12; k++) chk("R4 stride order", cap[k], AW'(1015 + 5 * k));
    cap_n = 0;
    do_acc(1015, 1'b1);
    idle(20);
    chk("R5 one more per access count", AW'(cap_n), 1);
    chk("R5 one more per access block", cap[0], 32'd1075);

    // R6: break stride
    cap_n = 0;
    do_acc(1030, 1'b0);
    idle(20);
    chk("R6 silent after break", AW'(cap_n), 0);
    do_acc(1045, 1'b0);
    idle(40);
    chk("R6 resume count", AW'(cap_n), 12);
    chk("R6 resume first", cap[0], 32'd1060);
    chk("R6 resume last", cap[11], 32'd1225);

    // R7: zero stride
    cap_n = 0;
    do_acc(5000, 1'b0); do_acc(5000, 1'b0); do_acc(5000, 1'b0); do_acc(5000, 1'b0);
    idle(20);
    chk("R7 zero stride silent", AW'(cap_n), 0);

    // R4: negative stride
    cap_n = 0;
    do_acc(9000, 1'b0); do_acc(8997, 1'b0); do_acc(8994, 1'b0);
    idle(40);
    chk("R4 negative count", AW'(cap_n), 12);
    chk("R4 negative first", cap[0], 32'd8991);
    chk("R4 negative last", cap[11], 32'd8958);

    // R8: eight interleaved streams, then replacement
    do_reset();
    mode = 2'b10;
    cap_n = 0;
    for (int r = 0; r < 3; r++)
      for (int s = 0; s < 8; s++) do_acc(AW'(20000 + s * 1000 + r * (s + 1)), 1'b0);
    idle(200);
    chk("R8 eight streams count", AW'(cap_n), 96);
    for (int s = 0; s < 8; s++) begin
      base = 20000 + s * 1000;
      chk($sformatf("R8 stream %0d first", s), cap[s * 12], AW'(base + 3 * (s + 1)));
      chk($sformatf("R8 stream %0d last", s), cap[s * 12 + 11], AW'(base + 14 * (s + 1)));
    end
    cap_n = 0;
    do_acc(40000, 1'b0); do_acc(40002, 1'b0); do_acc(40004, 1'b0);
    idle(40);
    chk("R8 new stream count", AW'(cap_n), 12);
    chk("R8 new stream first", cap[0], 32'd40006);
    cap_n = 0;
    do_acc(21006, 1'b0);
    idle(10);
    chk("R8 younger slot kept count", AW'(cap_n), 1);
    chk("R8 younger slot kept block", cap[0], 32'd21030);
    cap_n = 0;
    do_acc(20003, 1'b0);
    idle(10);
    chk("R8 oldest slot evicted", AW'(cap_n), 0);

    // R9: backpressure with next-line requests
    mode = 2'b01;
    idle(2);
    cap_n = 0;
    pf_ready = 1'b0;
    for (int i = 1; i <= 6; i++) do_acc(AW'(i * 100), 1'b0);
    idle(1);
    #1;
    chk("R9 stalled valid", AW'(pf_valid), 1);
    chk("R9 stalled head", pf_blk, 32'd101);
    idle(3);
    #1;
    chk("R9 head stable", pf_blk, 32'd101);
    pf_ready = 1'b1;
    idle(10);
    chk("R9 delivered count", AW'(cap_n), 4);
    for (int k = 0; k < 4; k++) chk("R9 delivered order", cap[k], AW'((k + 1) * 100 + 1));

    // R1: reset while requests wait
    pf_ready = 1'b0;
    do_acc(700, 1'b0); do_acc(800, 1'b0);
    idle(1);
    do_reset();
    #1;
    chk("R1 valid after mid-run reset", AW'(pf_valid), 0);
    cap_n = 0;
    pf_ready = 1'b1;
    idle(5);
    chk("R1 nothing delivered after reset", AW'(cap_n), 0);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

endmodule